// File: doc/BRIEF.md
# Ping-pong OUT endpoint receive buffer

This block is the receive store of one USB device OUT endpoint. It holds two equal memory banks. A packet-side write interface marks the start of each payload, delivers its bytes one per cycle and marks its end. The block writes the payload into the next bank in strict alternation, counts the bytes and replies with a one-cycle ACK or NAK pulse after the end strobe. Serial decoding, PID and CRC handling are done elsewhere.

On the processor side, a status word holds a ready flag for each bank, the index of the bank the processor currently owns, and the byte count of that bank. A data port shows the next unread byte of the owned bank, and a pop strobe advances it. The processor releases the owned bank through a clear strobe with a bank mask. Ownership then passes to the other bank, so the bus can fill one bank while software drains the other. An interrupt line stays high while any bank holds an unreleased payload.

Top module: `pp_out_ep_buffer`

## Requirements
- R1: The packet side can fill one bank while the processor pops bytes from the other bank, and neither transfer disturbs the other.
- R2: After reset the first accepted payload goes to bank 0. Accepted payloads then alternate between bank 1 and bank 0. A refused packet does not move the fill position.
- R3: One cycle after the end strobe of an accepted packet, `pkt_ack` pulses for one cycle. A second packet sent right after that pulse is accepted into the other bank. `pkt_ack` and `pkt_nak` are never high together.
- R4: When a bank finishes receiving, its ready flag rises in the same cycle as the ACK pulse. Status bit 0 is the flag of bank 0 and status bit 1 is the flag of bank 1.
- R5: `cpu_irq` is high exactly while at least one ready flag is set.
- R6: Status bit 2 gives the index of the processor-owned bank. Bits 3 upward give the byte count of that bank, or zero when that bank is not ready. Ownership follows fill order, so it always names the oldest unreleased bank.
- R7: `cpu_fifo_data` shows the next unread byte of the owned bank, and a `cpu_pop` cycle advances to the following byte. Once all counted bytes are read, or when no bank is ready, the port shows zero and a pop has no effect.
- R8: A clear cycle whose mask bit matches the owned, ready bank drops that flag, makes the bank free and moves ownership to the other bank. A mask bit for the bank that is not owned is ignored.
- R9: If bank 1 is ready when bank 0 is released, its flag stays set and the byte count and data port switch to bank 1.
- R10: A packet that starts while both banks are full is discarded. It is answered with NAK, and neither bank's flag, count nor data changes.
- R11: Bytes beyond the bank depth are dropped. The stored count saturates at the depth and the packet is still acknowledged.
- R12: After reset both flags are clear, the owned bank is 0, the count is zero, `cpu_irq` is low and the data port reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_start | input | 1 | Start of an OUT payload |
| pkt_valid | input | 1 | Byte on `pkt_data` is valid |
| pkt_data | input | DATA_W | Payload byte |
| pkt_end | input | 1 | End of the payload |
| pkt_ack | output | 1 | Payload stored (one-cycle pulse) |
| pkt_nak | output | 1 | Payload refused (one-cycle pulse) |
| cpu_pop | input | 1 | Advance the data port by one byte |
| cpu_fifo_data | output | DATA_W | Next unread byte of the owned bank |
| cpu_clr_en | input | 1 | Release strobe |
| cpu_clr_mask | input | 2 | Bank mask for the release strobe |
| cpu_status | output | 3+CNT_W | {count, owned bank, ready1, ready0} |
| cpu_irq | output | 1 | Endpoint interrupt |

## Verification
The bench builds the block with an eight-byte bank depth instead of the default 64. With that depth, a ten-byte packet is enough to reach count saturation and dropped bytes. A full-bank read-out and the both-banks-full refusal then take only a few dozen cycles. Eight bits of data width keep the byte pattern readable in failure messages. A packet that fills bank 0 is sent while bank 1 is being drained, and a zero-length packet shows that a ready flag can be set with a count of zero.

// File: rtl/pp_ep_pkg.sv
package pp_ep_pkg;

   // response pulse selector on the packet side
   typedef enum logic [1:0] {
      RESP_IDLE = 2'd0,
      RESP_ACK  = 2'd1,
      RESP_NAK  = 2'd2
   } pp_resp_e;

   // status word field positions
   localparam int unsigned STAT_RDY0    = 0;
   localparam int unsigned STAT_RDY1    = 1;
   localparam int unsigned STAT_OWN     = 2;
   localparam int unsigned STAT_CNT_LSB = 3;

   localparam int unsigned NUM_BANKS = 2;

endpackage

// File: rtl/pp_ep_bank_mem.sv
module pp_ep_bank_mem #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 64,
   localparam int unsigned AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         store[waddr] <= wdata;
      end
   end

   assign rdata = store[raddr];

endmodule

// File: rtl/pp_ep_fill_ctrl.sv
module pp_ep_fill_ctrl
   import pp_ep_pkg::*;
#(
   parameter int unsigned DEPTH = 64,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pkt_start,
   input  logic                 pkt_valid,
   input  logic                 pkt_end,
   input  logic [NUM_BANKS-1:0] bank_ready,
   output logic [NUM_BANKS-1:0] bank_we,
   output logic [AW-1:0]        bank_waddr,
   output logic                 done,
   output logic                 done_bank,
   output logic [CW-1:0]        done_count,
   output logic                 pkt_ack,
   output logic                 pkt_nak
);

   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   logic          wr_bank;
   logic          in_pkt;
   logic          taking;
   logic [CW-1:0] wr_ptr;
   logic          byte_wr;
   pp_resp_e      resp_q;

   assign byte_wr    = pkt_valid && in_pkt && taking && (wr_ptr < DEPTH_C);
   assign bank_waddr = wr_ptr[AW-1:0];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_we
      assign bank_we[b] = byte_wr && (wr_bank == 1'(b));
   end

   assign done       = pkt_end && in_pkt && taking;
   assign done_bank  = wr_bank;
   assign done_count = wr_ptr + CW'(byte_wr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_bank <= 1'b0;
         in_pkt  <= 1'b0;
         taking  <= 1'b0;
         wr_ptr  <= '0;
         resp_q  <= RESP_IDLE;
      end else begin
         resp_q <= RESP_IDLE;
         if (pkt_start) begin
            in_pkt <= 1'b1;
            taking <= !bank_ready[wr_bank];
            wr_ptr <= '0;
         end else begin
            if (byte_wr) begin
               wr_ptr <= wr_ptr + 1'b1;
            end
            if (pkt_end && in_pkt) begin
               in_pkt <= 1'b0;
               taking <= 1'b0;
               if (taking) begin
                  resp_q  <= RESP_ACK;
                  wr_bank <= !wr_bank;
               end else begin
                  resp_q <= RESP_NAK;
               end
            end
         end
      end
   end

   assign pkt_ack = (resp_q == RESP_ACK);
   assign pkt_nak = (resp_q == RESP_NAK);

endmodule

// File: rtl/pp_ep_drain_ctrl.sv
module pp_ep_drain_ctrl
   import pp_ep_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 64,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 done,
   input  logic                 done_bank,
   input  logic [CW-1:0]        done_count,
   input  logic                 cpu_pop,
   input  logic                 cpu_clr_en,
   input  logic [NUM_BANKS-1:0] cpu_clr_mask,
   input  logic [DATA_W-1:0]    bank_rdata [NUM_BANKS],
   output logic [NUM_BANKS-1:0] bank_ready,
   output logic [AW-1:0]        bank_raddr,
   output logic                 own_bank,
   output logic [CW-1:0]        own_count,
   output logic [DATA_W-1:0]    fifo_data
);

   logic [CW-1:0] cnt_q [NUM_BANKS];
   logic [CW-1:0] rd_ptr;
   logic          own_rdy;
   logic          more;
   logic          release_own;

   assign own_rdy     = bank_ready[own_bank];
   assign own_count   = own_rdy ? cnt_q[own_bank] : '0;
   assign more        = own_rdy && (rd_ptr < cnt_q[own_bank]);
   assign release_own = cpu_clr_en && cpu_clr_mask[own_bank] && own_rdy;
   assign bank_raddr  = rd_ptr[AW-1:0];
   assign fifo_data   = more ? bank_rdata[own_bank] : '0;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bank_ready[b] <= 1'b0;
            cnt_q[b]      <= '0;
         end else if (done && (done_bank == 1'(b))) begin
            bank_ready[b] <= 1'b1;
            cnt_q[b]      <= done_count;
         end else if (release_own && (own_bank == 1'(b))) begin
            bank_ready[b] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         own_bank <= 1'b0;
         rd_ptr   <= '0;
      end else if (release_own) begin
         own_bank <= !own_bank;
         rd_ptr   <= '0;
      end else if (cpu_pop && more) begin
         rd_ptr <= rd_ptr + 1'b1;
      end
   end

endmodule

// File: rtl/pp_out_ep_buffer.sv
module pp_out_ep_buffer
   import pp_ep_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned BANK_DEPTH = 64,
   localparam int unsigned AW        = $clog2(BANK_DEPTH),
   localparam int unsigned CNT_W     = $clog2(BANK_DEPTH + 1),
   localparam int unsigned STAT_W    = STAT_CNT_LSB + CNT_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pkt_start,
   input  logic                 pkt_valid,
   input  logic [DATA_W-1:0]    pkt_data,
   input  logic                 pkt_end,
   output logic                 pkt_ack,
   output logic                 pkt_nak,
   input  logic                 cpu_pop,
   output logic [DATA_W-1:0]    cpu_fifo_data,
   input  logic                 cpu_clr_en,
   input  logic [1:0]           cpu_clr_mask,
   output logic [STAT_W-1:0]    cpu_status,
   output logic                 cpu_irq
);

   if (BANK_DEPTH < 2) begin : g_bad_depth
      $error("pp_out_ep_buffer: BANK_DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("pp_out_ep_buffer: DATA_W must be at least 1");
   end

   logic [NUM_BANKS-1:0] bank_we;
   logic [NUM_BANKS-1:0] bank_ready;
   logic [AW-1:0]        waddr;
   logic [AW-1:0]        raddr;
   logic [DATA_W-1:0]    rdata [NUM_BANKS];
   logic                 done;
   logic                 done_bank;
   logic [CNT_W-1:0]     done_count;
   logic                 own_bank;
   logic [CNT_W-1:0]     own_count;

   pp_ep_fill_ctrl #(.DEPTH(BANK_DEPTH)) u_fill (
      .clk        (clk),
      .rst_n      (rst_n),
      .pkt_start  (pkt_start),
      .pkt_valid  (pkt_valid),
      .pkt_end    (pkt_end),
      .bank_ready (bank_ready),
      .bank_we    (bank_we),
      .bank_waddr (waddr),
      .done       (done),
      .done_bank  (done_bank),
      .done_count (done_count),
      .pkt_ack    (pkt_ack),
      .pkt_nak    (pkt_nak)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      pp_ep_bank_mem #(.DATA_W(DATA_W), .DEPTH(BANK_DEPTH)) u_mem (
         .clk   (clk),
         .we    (bank_we[b]),
         .waddr (waddr),
         .wdata (pkt_data),
         .raddr (raddr),
         .rdata (rdata[b])
      );
   end

   pp_ep_drain_ctrl #(.DATA_W(DATA_W), .DEPTH(BANK_DEPTH)) u_drain (
      .clk          (clk),
      .rst_n        (rst_n),
      .done         (done),
      .done_bank    (done_bank),
      .done_count   (done_count),
      .cpu_pop      (cpu_pop),
      .cpu_clr_en   (cpu_clr_en),
      .cpu_clr_mask (cpu_clr_mask),
      .bank_rdata   (rdata),
      .bank_ready   (bank_ready),
      .bank_raddr   (raddr),
      .own_bank     (own_bank),
      .own_count    (own_count),
      .fifo_data    (cpu_fifo_data)
   );

   assign cpu_status = {own_count, own_bank, bank_ready[1], bank_ready[0]};
   assign cpu_irq    = |bank_ready;

endmodule

// File: rtl/pp_out_ep_buffer_chk.sv
module pp_out_ep_buffer_chk #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned BANK_DEPTH = 64,
   localparam int unsigned CNT_W     = $clog2(BANK_DEPTH + 1),
   localparam int unsigned STAT_W    = 3 + CNT_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pkt_ack,
   input logic              pkt_nak,
   input logic [DATA_W-1:0] cpu_fifo_data,
   input logic              cpu_clr_en,
   input logic [1:0]        cpu_clr_mask,
   input logic [STAT_W-1:0] cpu_status,
   input logic              cpu_irq
);

   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(BANK_DEPTH);

   logic [CNT_W-1:0] cnt_f;
   assign cnt_f = cpu_status[STAT_W-1:3];

   assert_resp_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(pkt_ack && pkt_nak));

   assert_rdy0_on_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_status[0]) |-> pkt_ack);

   assert_rdy1_on_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_status[1]) |-> pkt_ack);

   assert_irq_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq == (cpu_status[1:0] != 2'b00));

   assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_status[1:0] == 2'b00) |-> (cpu_fifo_data == '0));

   assert_rdy0_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_status[0]) |-> $past(cpu_clr_en && cpu_clr_mask[0]));

   assert_rdy1_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_status[1]) |-> $past(cpu_clr_en && cpu_clr_mask[1]));

   assert_switch_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cpu_status[0]) && cpu_status[1]) |-> cpu_status[2]);

   assert_nak_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_nak |-> (!$rose(cpu_status[0]) && !$rose(cpu_status[1])));

   assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_f <= DEPTH_C);

endmodule

bind pp_out_ep_buffer pp_out_ep_buffer_chk #(
   .DATA_W     (DATA_W),
   .BANK_DEPTH (BANK_DEPTH)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .pkt_ack       (pkt_ack),
   .pkt_nak       (pkt_nak),
   .cpu_fifo_data (cpu_fifo_data),
   .cpu_clr_en    (cpu_clr_en),
   .cpu_clr_mask  (cpu_clr_mask),
   .cpu_status    (cpu_status),
   .cpu_irq       (cpu_irq)
);

// File: tb/pp_out_ep_buffer_test.sv
module pp_out_ep_buffer_test;

   localparam int unsigned DW    = 8;
   localparam int unsigned DEPTH = 8;
   localparam int unsigned CW    = $clog2(DEPTH + 1);
   localparam int unsigned SW    = 3 + CW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pkt_start = 1'b0;
   logic          pkt_valid = 1'b0;
   logic [DW-1:0] pkt_data = '0;
   logic          pkt_end = 1'b0;
   logic          pkt_ack;
   logic          pkt_nak;
   logic          cpu_pop = 1'b0;
   logic [DW-1:0] cpu_fifo_data;
   logic          cpu_clr_en = 1'b0;
   logic [1:0]    cpu_clr_mask = 2'b00;
   logic [SW-1:0] cpu_status;
   logic          cpu_irq;

   int total = 0;
   int bad   = 0;
   logic          exp_resp_q [$];
   logic [DW-1:0] exp_data_q [$];

   always #5 clk = ~clk;

   pp_out_ep_buffer #(.DATA_W(DW), .BANK_DEPTH(DEPTH)) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .pkt_start     (pkt_start),
      .pkt_valid     (pkt_valid),
      .pkt_data      (pkt_data),
      .pkt_end       (pkt_end),
      .pkt_ack       (pkt_ack),
      .pkt_nak       (pkt_nak),
      .cpu_pop       (cpu_pop),
      .cpu_fifo_data (cpu_fifo_data),
      .cpu_clr_en    (cpu_clr_en),
      .cpu_clr_mask  (cpu_clr_mask),
      .cpu_status    (cpu_status),
      .cpu_irq       (cpu_irq)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [SW-1:0] st(input bit r0, input bit r1, input bit own,
                                        input int cnt);
      return {CW'(cnt), own, r1, r0};
   endfunction

   // response monitor: pops the expected ACK/NAK as the design answers
   always @(negedge clk) begin
      if (rst_n && (pkt_ack || pkt_nak)) begin
         if (exp_resp_q.size() == 0) begin
            check(1'b0, "R3 unexpected response", {30'd0, pkt_nak, pkt_ack}, 0);
         end else begin
            logic want_ack;
            want_ack = exp_resp_q.pop_front();
            check(pkt_ack == want_ack && pkt_nak == !want_ack,
                  want_ack ? "R3 ack" : "R10 nak", {30'd0, pkt_nak, pkt_ack},
                  want_ack ? 1 : 2);
         end
      end
   end

   task automatic send_pkt(input int n, input logic [DW-1:0] base, input bit acc);
      exp_resp_q.push_back(acc);
      if (acc) begin
         for (int i = 0; i < n && i < DEPTH; i++) exp_data_q.push_back(base + DW'(i));
      end
      @(negedge clk);
      pkt_start = 1'b1;
      @(negedge clk);
      pkt_start = 1'b0;
      for (int i = 0; i < n; i++) begin
         pkt_valid = 1'b1;
         pkt_data  = base + DW'(i);
         @(negedge clk);
      end
      pkt_valid = 1'b0;
      pkt_end   = 1'b1;
      @(negedge clk);
      pkt_end = 1'b0;
      @(negedge clk);
   endtask

   task automatic read_bytes(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (exp_data_q.size() == 0) begin
            check(1'b0, req, cpu_fifo_data, 0);
         end else begin
            logic [DW-1:0] e;
            e = exp_data_q.pop_front();
            check(cpu_fifo_data == e, req, cpu_fifo_data, e);
         end
         cpu_pop = 1'b1;
      end
      @(negedge clk);
      cpu_pop = 1'b0;
   endtask

   task automatic release_banks(input logic [1:0] m);
      @(negedge clk);
      cpu_clr_en   = 1'b1;
      cpu_clr_mask = m;
      @(negedge clk);
      cpu_clr_en   = 1'b0;
      cpu_clr_mask = 2'b00;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      check(cpu_status == st(0, 0, 0, 0), "R12 status", cpu_status, st(0, 0, 0, 0));
      check(cpu_irq == 1'b0, "R12 irq", cpu_irq, 0);
      check(cpu_fifo_data == '0, "R12 data", cpu_fifo_data, 0);

      // R2 R4 R6: first packet to bank 0
      send_pkt(3, 8'h10, 1'b1);
      check(cpu_status == st(1, 0, 0, 3), "R2 R4 R6 bank0", cpu_status, st(1, 0, 0, 3));
      check(cpu_irq == 1'b1, "R5 irq high", cpu_irq, 1);

      // R3: back-to-back packet lands in bank 1
      send_pkt(5, 8'h40, 1'b1);
      check(cpu_status == st(1, 1, 0, 3), "R3 R4 bank1", cpu_status, st(1, 1, 0, 3));

      // R10: both full, refused, nothing changes
      send_pkt(4, 8'h77, 1'b0);
      check(cpu_status == st(1, 1, 0, 3), "R10 unchanged", cpu_status, st(1, 1, 0, 3));

      // R8: mask for the non-owned bank is ignored
      release_banks(2'b10);
      check(cpu_status == st(1, 1, 0, 3), "R8 ignored", cpu_status, st(1, 1, 0, 3));

      // R7: drain bank 0, then past-the-end reads zero
      read_bytes(3, "R7 data");
      check(cpu_fifo_data == '0, "R7 past end", cpu_fifo_data, 0);
      @(negedge clk);
      cpu_pop = 1'b1;
      @(negedge clk);
      cpu_pop = 1'b0;
      check(cpu_fifo_data == '0, "R7 pop past end", cpu_fifo_data, 0);
      check(cpu_status == st(1, 1, 0, 3), "R7 count kept", cpu_status, st(1, 1, 0, 3));

      // R9: release bank 0, bank 1 becomes owned
      release_banks(2'b01);
      check(cpu_status == st(0, 1, 1, 5), "R9 switch", cpu_status, st(0, 1, 1, 5));

      // R1 R11: overlong packet into bank 0 while bank 1 is drained
      fork
         send_pkt(10, 8'hA0, 1'b1);
         begin
            @(negedge clk);
            read_bytes(5, "R1 concurrent read");
         end
      join
      check(cpu_status == st(1, 1, 1, 5), "R1 both ready", cpu_status, st(1, 1, 1, 5));
      release_banks(2'b10);
      check(cpu_status == st(1, 0, 0, DEPTH), "R11 saturated", cpu_status,
            st(1, 0, 0, DEPTH));
      read_bytes(DEPTH, "R11 data");
      check(cpu_fifo_data == '0, "R11 dropped bytes", cpu_fifo_data, 0);
      release_banks(2'b01);
      check(cpu_status == st(0, 0, 1, 0), "R8 released", cpu_status, st(0, 0, 1, 0));
      check(cpu_irq == 1'b0, "R5 irq low", cpu_irq, 0);

      // R2: alternation continues with bank 1
      send_pkt(2, 8'h55, 1'b1);
      check(cpu_status == st(0, 1, 1, 2), "R2 alternate", cpu_status, st(0, 1, 1, 2));
      read_bytes(2, "R7 bank1 data");
      release_banks(2'b10);
      check(cpu_status == st(0, 0, 0, 0), "R8 idle", cpu_status, st(0, 0, 0, 0));

      // R4 R5: zero-length packet into bank 0
      send_pkt(0, 8'h00, 1'b1);
      check(cpu_status == st(1, 0, 0, 0), "R4 empty payload", cpu_status, st(1, 0, 0, 0));
      check(cpu_irq == 1'b1, "R5 irq empty payload", cpu_irq, 1);
      check(cpu_fifo_data == '0, "R7 empty data", cpu_fifo_data, 0);
      release_banks(2'b01);
      check(cpu_irq == 1'b0, "R5 irq cleared", cpu_irq, 0);

      repeat (3) @(negedge clk);
      check(exp_resp_q.size() == 0, "R3 responses seen", exp_resp_q.size(), 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule